// File: doc/BRIEF.md
# Ultra DMA write-burst receiver

This block is the device end of a write burst on a 16-bit parallel disk interface running the source-synchronous Ultra DMA protocol. Once the fast mode has been enabled and a DMA write command starts, it raises its transfer request and waits for the host's acknowledge. It then drives its active-low ready line and captures a data word on every change of level of the host strobe, whether rising or falling. The words go into a small first-word-fall-through FIFO that the core side drains.

The ready line is withdrawn when the FIFO is close to full or when the core asks for a pause. Enough room is always held back for the words the host may still send after it sees ready go away. The burst can end in two ways. The host can raise its stop line. The device can withdraw ready, wait a fixed interval and then drop its request. In both cases the host hands over its CRC word on the data bus at the moment it releases the acknowledge. The block compares that word with its own CRC over the burst. A mismatch sets a sticky error flag, which the command completion logic reads and which the next command start clears.

All inputs are taken to be synchronous to `clk_i`; edges on the strobe are found by comparing each sample with the previous one.

Top module: `udma_out_rx`

## Requirements
- R1: While `rst_ni` is low and right after it rises: `xfer_req_o`=0, `dev_rdy_no`=1, `fast_mode_o`=0, `rd_valid_o`=0, `crc_error_o`=0, `burst_done_o`=0.
- R2: `fast_mode_o` is set by a `mode_set_i` pulse and cleared only by reset. While it is clear, `cmd_start_i` is ignored and `xfer_req_o` stays 0.
- R3: With fast mode on, `cmd_start_i` raises `xfer_req_o` after one clock edge. Once `xfer_ack_ni`=0 and `host_stop_i`=0 are seen at an edge, `dev_rdy_no` goes low after that edge and the CRC is seeded with 16'h4ABA.
- R4: During transfer (acknowledge low, stop low), every edge at which `host_strb_i` differs from its value at the previous edge pushes `data_i` into the FIFO. `rd_data_o` presents the words in arrival order, and a word leaves when `rd_valid_o` and `rd_ready_i` are both 1 at an edge.
- R5: The CRC is updated once per captured word, bit 15 first. For each bit, the feedback is crc[15] xor the data bit; the register shifts left and is xored with 16'h1021 when the feedback is 1.
- R6: `dev_rdy_no` is 1 in a transfer cycle when the FIFO's free space after the edge is SKID (3) or less, or when `pause_i` is 1; it returns to 0 when space exceeds SKID and `pause_i` is 0. With DEPTH 8, five held words withdraw ready and SKID further words still fit without loss.
- R7: A `dev_stop_i` pulse during transfer raises `dev_rdy_no` at once. `xfer_req_o` stays 1 for RP_CYC (4) cycles with ready withdrawn and then falls.
- R8: `host_stop_i`=1 during transfer drops `xfer_req_o` and raises `dev_rdy_no` after one edge.
- R9: In the ending phase, the edge at which `xfer_ack_ni` is seen high compares `data_i` with the CRC. After that edge `burst_done_o` is 1 for one cycle, and `crc_error_o` is set if the two differ.
- R10: `crc_error_o` stays 1 until the next `cmd_start_i`, which clears it.
- R11: Outside a burst, strobe changes, `data_i` and `host_stop_i` have no effect: no word enters the FIFO and `xfer_req_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Enables the fast burst mode |
| cmd_start_i | input | 1 | Start of a DMA write command |
| dev_stop_i | input | 1 | Core asks to end the burst |
| pause_i | input | 1 | Core asks to pause the burst |
| xfer_ack_ni | input | 1 | Host DMA acknowledge, active low |
| host_stop_i | input | 1 | Host stop request |
| host_strb_i | input | 1 | Host data strobe, both edges used |
| data_i | input | 16 | Data bus from the host |
| rd_ready_i | input | 1 | Core takes the FIFO head word |
| xfer_req_o | output | 1 | Device DMA request |
| dev_rdy_no | output | 1 | Device ready for data, active low |
| rd_valid_o | output | 1 | FIFO holds a word |
| rd_data_o | output | 16 | FIFO head word |
| fast_mode_o | output | 1 | Fast burst mode is enabled |
| crc_error_o | output | 1 | Sticky CRC mismatch flag |
| burst_done_o | output | 1 | One-cycle pulse at burst end |

## Verification
The assertions assume that the host obeys the protocol. It sends at most SKID words after it sees ready withdrawn. It asserts stop and releases the acknowledge only after the request has been granted, and it never toggles the strobe more than once per clock. The bench drives every input on the falling clock edge and changes the strobe at most once per cycle. It stops feeding words as soon as the skid allowance is used, and it raises stop before it releases the acknowledge, so the stimulus stays inside those assumptions.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_XFER,
    PH_DRAIN,
    PH_END
  } phase_e;

  localparam logic [15:0] CRC_SEED = 16'h4ABA;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  function automatic logic [15:0] crc16_word(input logic [15:0] c_in, input logic [15:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 15; i >= 0; i--) begin
      c = (c[15] ^ d[i]) ? ({c[14:0], 1'b0} ^ CRC_POLY) : {c[14:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/udma_strobe_cap.sv
module udma_strobe_cap #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          strb_i,
  input  logic [DW-1:0] data_i,
  output logic          word_vld_o,
  output logic [DW-1:0] word_o
);
  logic strb_q;

  // idle strobe level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b1;
    else         strb_q <= strb_i;
  end

  assign word_vld_o = en_i && (strb_i != strb_q);
  assign word_o     = data_i;
endmodule

// File: rtl/udma_word_fifo.sv
module udma_word_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop_ok;

  assign pop_ok = pop_i && (cnt_q != '0);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok) rptr_q <= ptr_inc(rptr_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  assign rd_valid_o = (cnt_q != '0);
  assign rd_data_o  = mem_q[rptr_q];
  assign count_o    = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && (cnt_q == CW'(DEPTH)) |-> pop_ok); // R6
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
  import udma_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        seed_i,
  input  logic        upd_i,
  input  logic [15:0] word_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (seed_i) crc_q <= CRC_SEED;
    else if (upd_i)  crc_q <= crc16_word(crc_q, word_i);
  end

  assign crc_o = crc_q;

  AST_CRC_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_i |=> crc_o == CRC_SEED); // R3

  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seed_i && !upd_i |=> $stable(crc_o)); // R5
endmodule

// File: rtl/udma_out_rx.sv
module udma_out_rx
  import udma_rx_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned SKID   = 3,
  parameter int unsigned RP_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_set_i,
  input  logic          cmd_start_i,
  input  logic          dev_stop_i,
  input  logic          pause_i,
  input  logic          xfer_ack_ni,
  input  logic          host_stop_i,
  input  logic          host_strb_i,
  input  logic [DW-1:0] data_i,
  input  logic          rd_ready_i,
  output logic          xfer_req_o,
  output logic          dev_rdy_no,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          fast_mode_o,
  output logic          crc_error_o,
  output logic          burst_done_o
);
  localparam int unsigned CW  = $clog2(DEPTH + 1);
  localparam int unsigned RCW = $clog2(RP_CYC + 1);

  phase_e         ph_q, ph_d;
  logic           mode_q, rdy_n_q, err_q, done_q;
  logic [RCW-1:0] rp_cnt_q, rdyhi_cnt_q;
  logic           ack, accept, push, pop;
  logic [DW-1:0]  cap_word;
  logic [CW-1:0]  fifo_cnt;
  logic [15:0]    crc;
  int             cnt_nxt;
  logic           room_ok;

  assign ack    = !xfer_ack_ni;
  assign accept = ack && !host_stop_i &&
                  (ph_q == PH_XFER || ph_q == PH_DRAIN || ph_q == PH_END);

  udma_strobe_cap #(.DW(DW)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (accept),
    .strb_i     (host_strb_i),
    .data_i     (data_i),
    .word_vld_o (push),
    .word_o     (cap_word)
  );

  udma_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .data_i     (cap_word),
    .pop_i      (rd_ready_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .count_o    (fifo_cnt)
  );

  assign pop = rd_ready_i && rd_valid_o;

  // CRC is defined over 16-bit words
  udma_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (ph_q == PH_REQ && ph_d == PH_XFER),
    .upd_i  (push),
    .word_i (16'(cap_word)),
    .crc_o  (crc)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (cmd_start_i && mode_q) ph_d = PH_REQ;
      PH_REQ:   if (ack && !host_stop_i) ph_d = PH_XFER;
      PH_XFER: begin
        if (host_stop_i)     ph_d = PH_END;
        else if (dev_stop_i) ph_d = PH_DRAIN;
      end
      PH_DRAIN: if (host_stop_i || rp_cnt_q == RCW'(RP_CYC - 1)) ph_d = PH_END;
      PH_END:   if (!ack) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  // free space seen after this edge decides ready
  assign cnt_nxt = int'(fifo_cnt) + int'(push) - int'(pop);
  assign room_ok = (int'(DEPTH) - cnt_nxt) > int'(SKID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      mode_q      <= 1'b0;
      rdy_n_q     <= 1'b1;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
      rp_cnt_q    <= '0;
      rdyhi_cnt_q <= '0;
    end else begin
      ph_q    <= ph_d;
      rdy_n_q <= !(ph_d == PH_XFER && room_ok && !pause_i);
      done_q  <= (ph_q == PH_END) && !ack;
      if (mode_set_i) mode_q <= 1'b1;
      if (cmd_start_i)                                         err_q <= 1'b0;
      else if (ph_q == PH_END && !ack && 16'(data_i) != crc)   err_q <= 1'b1;
      if (ph_q == PH_DRAIN) rp_cnt_q <= rp_cnt_q + RCW'(1);
      else                  rp_cnt_q <= '0;
      if (!rdy_n_q)                        rdyhi_cnt_q <= '0;
      else if (rdyhi_cnt_q != RCW'(RP_CYC)) rdyhi_cnt_q <= rdyhi_cnt_q + RCW'(1);
    end
  end

  assign xfer_req_o   = (ph_q == PH_REQ) || (ph_q == PH_XFER) || (ph_q == PH_DRAIN);
  assign dev_rdy_no   = rdy_n_q;
  assign fast_mode_o  = mode_q;
  assign crc_error_o  = err_q;
  assign burst_done_o = done_q;

  AST_MODE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> fast_mode_o); // R2

  AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(xfer_req_o) && !$past(host_stop_i) |-> rdyhi_cnt_q >= RCW'(RP_CYC)); // R7

  AST_HOST_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_XFER && host_stop_i |=> !xfer_req_o && dev_rdy_no); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_error_o && !cmd_start_i |=> crc_error_o); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ph_q == PH_IDLE |-> !push && dev_rdy_no); // R11

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_done_o |=> !burst_done_o); // R9
endmodule

// File: tb/tb_udma_out_rx.sv
module tb_udma_out_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int SKID   = 3;
  localparam int RP_CYC = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_set_i = 0, cmd_start_i = 0, dev_stop_i = 0, pause_i = 0;
  logic        xfer_ack_ni = 1, host_stop_i = 0, host_strb_i = 1, rd_ready_i = 0;
  logic [15:0] data_i = '0;
  logic        xfer_req_o, dev_rdy_no, rd_valid_o, fast_mode_o, crc_error_o, burst_done_o;
  logic [15:0] rd_data_o;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic [15:0] crc_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  udma_out_rx #(.DW(16), .DEPTH(DEPTH), .SKID(SKID), .RP_CYC(RP_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_set_i(mode_set_i), .cmd_start_i(cmd_start_i),
    .dev_stop_i(dev_stop_i), .pause_i(pause_i), .xfer_ack_ni(xfer_ack_ni),
    .host_stop_i(host_stop_i), .host_strb_i(host_strb_i), .data_i(data_i),
    .rd_ready_i(rd_ready_i), .xfer_req_o(xfer_req_o), .dev_rdy_no(dev_rdy_no),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .fast_mode_o(fast_mode_o),
    .crc_error_o(crc_error_o), .burst_done_o(burst_done_o)
  );

  function automatic logic [15:0] model_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r = c;
    for (int b = 0; b < 16; b++) begin
      logic fb = r[15] ^ w[15 - b];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic start_burst();
    cmd_start_i = 1; tick(); cmd_start_i = 0;
    chk("R3 request raised", xfer_req_o, 1);
    chk("R10 error cleared by start", crc_error_o, 0);
    xfer_ack_ni = 0; host_stop_i = 0; tick();
    chk("R3 ready asserted", dev_rdy_no, 0);
    crc_m = 16'h4ABA;
  endtask

  task automatic send_word(input logic [15:0] w);
    data_i = w; host_strb_i = ~host_strb_i;
    exp_q.push_back(w);
    crc_m = model_crc(crc_m, w);
    tick();
  endtask

  task automatic drain(input int n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] e = exp_q.pop_front();
      chk("R4 word valid", rd_valid_o, 1);
      chk("R4 word order", rd_data_o, e);
      rd_ready_i = 1; tick();
    end
    rd_ready_i = 0;
    chk("R4 fifo empty", rd_valid_o, 0);
  endtask

  task automatic host_end(input logic [15:0] crc_word, input logic exp_err);
    host_stop_i = 1; tick();
    chk("R8 request dropped", xfer_req_o, 0);
    chk("R8 ready withdrawn", dev_rdy_no, 1);
    xfer_ack_ni = 1; data_i = crc_word; tick();
    chk("R9 done pulse", burst_done_o, 1);
    chk("R9 crc verdict", crc_error_o, exp_err);
    host_stop_i = 0; tick();
    chk("R9 done one cycle", burst_done_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 0; tick(); tick();
    chk("R1 req", xfer_req_o, 0); chk("R1 rdy", dev_rdy_no, 1);
    chk("R1 mode", fast_mode_o, 0); chk("R1 valid", rd_valid_o, 0);
    chk("R1 err", crc_error_o, 0); chk("R1 done", burst_done_o, 0);
    rst_ni = 1; tick();
    chk("R1 req after release", xfer_req_o, 0);
    chk("R1 rdy after release", dev_rdy_no, 1);
  endtask

  task automatic t_mode_gate();
    cmd_start_i = 1; tick(); cmd_start_i = 0; tick();
    chk("R2 start ignored without mode", xfer_req_o, 0);
    mode_set_i = 1; tick(); mode_set_i = 0;
    chk("R2 mode set", fast_mode_o, 1);
  endtask

  task automatic t_flow_host_end();
    start_burst();
    for (int i = 0; i < 4; i++) send_word(16'h1000 + 16'(i * 7));
    chk("R6 ready with room", dev_rdy_no, 0);
    send_word(16'hA5A5);
    chk("R6 ready withdrawn near full", dev_rdy_no, 1);
    for (int i = 0; i < SKID; i++) send_word(16'hC000 | 16'(i));
    chk("R6 skid words held", rd_valid_o, 1);
    drain(8);
    chk("R6 ready back after drain", dev_rdy_no, 0);
    host_end(crc_m, 0);
  endtask

  task automatic t_bad_crc();
    start_burst();
    send_word(16'h0001); send_word(16'hFFFF);
    host_end(~crc_m, 1);
    tick(); tick();
    chk("R10 error sticky", crc_error_o, 1);
    drain(2);
    chk("R10 error still set", crc_error_o, 1);
  endtask

  task automatic t_pause_dev_end();
    start_burst();
    pause_i = 1; tick();
    chk("R6 paused", dev_rdy_no, 1);
    pause_i = 0; tick();
    chk("R6 resumed", dev_rdy_no, 0);
    send_word(16'h3C3C);
    dev_stop_i = 1; tick(); dev_stop_i = 0;
    chk("R7 ready withdrawn", dev_rdy_no, 1);
    chk("R7 request held", xfer_req_o, 1);
    for (int i = 1; i < RP_CYC; i++) begin
      tick();
      chk("R7 request held in wait", xfer_req_o, 1);
    end
    tick();
    chk("R7 request dropped after wait", xfer_req_o, 0);
    host_stop_i = 1; xfer_ack_ni = 1; data_i = crc_m; tick();
    chk("R9 done after device end", burst_done_o, 1);
    chk("R5 crc good", crc_error_o, 0);
    host_stop_i = 0; tick();
    drain(1);
  endtask

  task automatic t_empty_burst();
    start_burst();
    host_end(16'h4ABA, 0);
    chk("R5 seed value on empty burst", crc_error_o, 0);
  endtask

  task automatic t_idle_ignore();
    for (int i = 0; i < 4; i++) begin
      data_i = 16'(i) * 16'h1111; host_strb_i = ~host_strb_i; host_stop_i = i[0];
      xfer_ack_ni = 1; tick();
    end
    host_stop_i = 0;
    chk("R11 no word captured", rd_valid_o, 0);
    chk("R11 no request", xfer_req_o, 0);
  endtask

  task automatic t_reset_mode();
    rst_ni = 0; tick(); rst_ni = 1; tick();
    chk("R2 mode cleared by reset", fast_mode_o, 0);
    cmd_start_i = 1; tick(); cmd_start_i = 0; tick();
    chk("R2 start ignored after reset", xfer_req_o, 0);
  endtask

  initial begin
    tick();
    t_reset();
    t_mode_gate();
    t_flow_host_end();
    t_bad_crc();
    t_pause_dev_end();
    t_empty_burst();
    t_idle_ignore();
    t_reset_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule